// File: doc/BRIEF.md
# Delayed-Residual Saturating Accumulator

This block keeps a running sum of signed samples that is meant to stay between a lower and an upper limit. The usual saturating adder puts the clamp inside a one-cycle loop. Here the register that accumulates (the "raw" value) is never clamped. Its zero point is allowed to drift. Each accepted sample produces a correction, the residual. The residual goes two ways:

- into a feed-forward sum that is added to the raw value to form the output;
- into a delay line of `FB_DEPTH` entries.

When a residual leaves the delay line it is added into the raw value, and the same amount is taken out of the feed-forward sum. The corrected output therefore does not change when a residual is folded back.

The residual is chosen according to where the raw value sits:

- **Raw value inside the limits:** the residual is the exact overshoot of the corrected value.
- **Raw value crosses a limit for the first time:** the residual pins the corrected value onto that limit.
- **Raw value stays beyond the same limit:** the residual cancels only the part of the new step that moves outward.

With a depth of one the output is an exact clamped sum. With larger depths the raw value can sit beyond a limit while the true value has already returned inside. The output can then drift from the exact answer, and the bench measures that error.

Samples enter and results leave through valid/ready streams. The input is accepted whenever `in_valid && in_ready`. `in_ready` is high while the output register is empty or is being drained in the same cycle. One result appears per accepted sample, in order. A result is held unchanged for as long as `out_ready` is low.

Top module: `resid_clamp_acc`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the raw value, the feed-forward sum and every delay entry are zero.
- R2: `in_ready` equals `!out_valid || out_ready`. A sample is taken on a clock edge where `in_valid && in_ready`, and its result is presented with `out_valid` high after that same edge, with one result per sample in input order.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R4: When the new raw value is above `LIM_HI` (below `LIM_LO`) and the previous raw value was not beyond that same limit, the output equals `LIM_HI` (`LIM_LO`).
- R5: When the new raw value lies within [`LIM_LO`, `LIM_HI`], the output equals the corrected value `c` = previous output + sample, clamped to the limits.
- R6: When the raw value stays above `LIM_HI` for a second or later sample, the residual is -x for a positive sample x and 0 otherwise. The output is then `c` - max(x, 0). The mirror rule applies below `LIM_LO`, with output `c` - min(x, 0).
- R7: The residual made by sample k is added to the raw value at sample k+`FB_DEPTH` and taken out of the feed-forward sum at that same sample. The raw value plus the feed-forward sum always equals the last output, and the feed-forward sum always equals the sum of the delay entries.
- R8: With `FB_DEPTH` = 1 every output equals an exact clamped running sum, clamp(previous + x).
- R9: With limits 0 and 88, from reset, samples 90 then 8 give outputs 88 then 88 for any depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed sample to add |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | IN_W+8 | Signed corrected accumulator value |

## Verification
The bench drives three instances at depths 1, 4 and 32 from one stimulus stream, including sequences that:

- enter the upper limit,
- stay beyond it with both outward and inward steps,
- cross straight to the lower limit.

A design that fed a residual back at the wrong sample, or forgot to take it out of the feed-forward sum, would show a jump in the output when the delayed residual arrives.

A residual calculator that ignored the previous limit state would clamp a staying step exactly, so it would lose the known deviation after 100, -5, 3. A calculator that ignored the step sign would hold the value at the limit after an inward step.

Random stalls on both streams probe the hold and ready rules. The depth-1 instance is compared against the exact clamp, and the error of the deeper instances is reported.

// File: rtl/rca_pkg.sv
`timescale 1ns/1ps
package rca_pkg;
  // where the raw (floating-base) value sits relative to the limits
  typedef enum logic [1:0] {
    ZONE_IN = 2'd0,
    ZONE_HI = 2'd1,
    ZONE_LO = 2'd2
  } zone_e;
endpackage

// File: rtl/rca_delay_line.sv
`timescale 1ns/1ps
module rca_delay_line #(
  parameter int DEPTH = 4,
  parameter int W     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic signed [W-1:0]     din,
  output logic [DEPTH-1:0][W-1:0] taps
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int k = 1; k < DEPTH; k++) begin
        taps[k] <= taps[k-1];
      end
    end
  end

  // R7
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ($signed(taps[0]) == $past(din)));

endmodule

// File: rtl/rca_resid_calc.sv
`timescale 1ns/1ps
module rca_resid_calc
  import rca_pkg::*;
#(
  parameter int W      = 24,
  parameter int LIM_LO = 0,
  parameter int LIM_HI = 88
) (
  input  logic signed [W-1:0] raw,
  input  logic signed [W-1:0] corr,
  input  logic signed [W-1:0] step,
  input  zone_e               zone_prev,
  output logic signed [W-1:0] resid,
  output zone_e               zone
);

  localparam logic signed [W-1:0] LO_V = W'(LIM_LO);
  localparam logic signed [W-1:0] HI_V = W'(LIM_HI);

  always_comb begin
    resid = '0;
    zone  = ZONE_IN;
    if (raw > HI_V) begin
      zone = ZONE_HI;
      if (zone_prev == ZONE_HI) resid = (step > 0) ? -step : '0;
      else                      resid = HI_V - corr;
    end else if (raw < LO_V) begin
      zone = ZONE_LO;
      if (zone_prev == ZONE_LO) resid = (step < 0) ? -step : '0;
      else                      resid = LO_V - corr;
    end else begin
      if (corr > HI_V)      resid = HI_V - corr;
      else if (corr < LO_V) resid = LO_V - corr;
    end
  end

endmodule

// File: rtl/resid_clamp_acc.sv
`timescale 1ns/1ps
module resid_clamp_acc
  import rca_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int LIM_LO   = 0,
  parameter int LIM_HI   = 88,
  parameter int FB_DEPTH = 4,
  localparam int ACC_W   = IN_W + 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_data
);

  localparam logic signed [ACC_W-1:0] LO_V = ACC_W'(LIM_LO);
  localparam logic signed [ACC_W-1:0] HI_V = ACC_W'(LIM_HI);

  logic signed [ACC_W-1:0] acc_q, ff_q;
  zone_e                   zone_q, zone_n;
  logic signed [ACC_W-1:0] x_ext, fb, raw_n, ff_n, corr, resid;
  logic [FB_DEPTH-1:0][ACC_W-1:0] taps;
  logic                    accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign x_ext    = ACC_W'(in_data);
  assign fb       = $signed(taps[FB_DEPTH-1]);
  assign raw_n    = acc_q + x_ext + fb;
  assign ff_n     = ff_q - fb;
  assign corr     = raw_n + ff_n;

  rca_resid_calc #(.W(ACC_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)) u_calc (
    .raw       (raw_n),
    .corr      (corr),
    .step      (x_ext),
    .zone_prev (zone_q),
    .resid     (resid),
    .zone      (zone_n)
  );

  rca_delay_line #(.DEPTH(FB_DEPTH), .W(ACC_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (resid),
    .taps     (taps)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ff_q      <= '0;
      zone_q    <= ZONE_IN;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept) begin
        acc_q    <= raw_n;
        ff_q     <= ff_n + resid;
        zone_q   <= zone_n;
        out_data <= corr + resid;
      end
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // sum of pending residuals, used only by the bookkeeping check
  logic signed [ACC_W-1:0] tap_sum;
  always_comb begin
    tap_sum = '0;
    for (int k = 0; k < FB_DEPTH; k++) tap_sum = tap_sum + $signed(taps[k]);
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q + ff_q == out_data));

  // R7
  ff_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ff_q == tap_sum);

  // R6
  stay_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zone_q == ZONE_HI && zone_n == ZONE_HI && x_ext > 0)
      |=> (out_data == $past(out_data)));

  // R6
  stay_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zone_q == ZONE_LO && zone_n == ZONE_LO && x_ext < 0)
      |=> (out_data == $past(out_data)));

  if (FB_DEPTH == 1) begin : g_exact
    // R8
    exact_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data >= LO_V && out_data <= HI_V));
  end

endmodule

// File: tb/resid_clamp_acc_tb.sv
`timescale 1ns/1ps
module resid_clamp_acc_tb;

  localparam int LO = 0;
  localparam int HI = 88;
  localparam int NMAX = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [15:0] in_data = '0;
  logic ov [3];
  logic ir [3];
  logic signed [23:0] od [3];

  always #2.5 clk = ~clk;

  resid_clamp_acc #(.FB_DEPTH(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[0]),
    .in_data(in_data), .out_valid(ov[0]), .out_ready(out_ready), .out_data(od[0]));
  resid_clamp_acc #(.FB_DEPTH(4)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[1]),
    .in_data(in_data), .out_valid(ov[1]), .out_ready(out_ready), .out_data(od[1]));
  resid_clamp_acc #(.FB_DEPTH(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[2]),
    .in_data(in_data), .out_valid(ov[2]), .out_ready(out_ready), .out_data(od[2]));

  int n_chk = 0, n_fail = 0;
  int m_acc [3], m_ff [3], m_zone [3], m_n [3];
  int rh [3][NMAX];
  int expq [3][NMAX];
  int got [3][NMAX];
  int wr [3], rd [3];
  int ex_val;
  int exq [NMAX];
  int stim [NMAX];
  int max_err [3];

  function automatic int dep(input int i);
    return (i == 0) ? 1 : (i == 1) ? 4 : 32;
  endfunction

  function automatic int clampi(input int v);
    return (v > HI) ? HI : (v < LO) ? LO : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_acc[i] = 0; m_ff[i] = 0; m_zone[i] = 0; m_n[i] = 0;
      wr[i] = 0; rd[i] = 0;
    end
    ex_val = 0;
  endtask

  // behavioural model: zone 0 inside, 1 above, 2 below
  task automatic model_step(input int x);
    int fb, raw, ffn, c, r, z;
    ex_val = clampi(ex_val + x);
    exq[wr[0]] = ex_val;
    for (int i = 0; i < 3; i++) begin
      fb  = (m_n[i] >= dep(i)) ? rh[i][m_n[i] - dep(i)] : 0;
      raw = m_acc[i] + x + fb;
      ffn = m_ff[i] - fb;
      c   = raw + ffn;
      if (raw > HI) begin
        z = 1;
        r = (m_zone[i] == 1) ? ((x > 0) ? -x : 0) : HI - c;
      end else if (raw < LO) begin
        z = 2;
        r = (m_zone[i] == 2) ? ((x < 0) ? -x : 0) : LO - c;
      end else begin
        z = 0;
        r = clampi(c) - c;
      end
      m_acc[i] = raw; m_ff[i] = ffn + r; m_zone[i] = z;
      rh[i][m_n[i]] = r; m_n[i]++;
      expq[i][wr[i]] = c + r; wr[i]++;
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    // R1
    for (int i = 0; i < 3; i++) begin
      chk(ov[i] == 1'b0, "R1 out_valid", int'(ov[i]), 0);
      chk(ir[i] == 1'b1, "R1 in_ready", int'(ir[i]), 1);
    end
  endtask

  task automatic run_phase(input int n, input bit rnd);
    int sent = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    while ((sent < n || rd[0] < wr[0]) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 3; i++) begin
        if (ov[i]) begin
          chk(int'(od[i]) == expq[i][rd[i]], stalled ? "R3 held result" : "R7 model",
              int'(od[i]), expq[i][rd[i]]);
        end
      end
      out_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
      if (sent < n && (!rnd || ($urandom % 3 != 0))) begin
        in_valid = 1'b1;
        in_data  = 16'(stim[sent]);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      for (int i = 0; i < 3; i++) begin
        chk(ir[i] == (!ov[i] || out_ready), "R2 in_ready", int'(ir[i]),
            int'(!ov[i] || out_ready));
      end
      for (int i = 0; i < 3; i++) begin
        if (ov[i] && out_ready) begin
          got[i][rd[i]] = int'(od[i]);
          if (i == 0) chk(int'(od[0]) == exq[rd[0]], "R8 exact clamp", int'(od[0]), exq[rd[0]]);
          else if ((int'(od[i]) - exq[rd[i]]) > max_err[i]) max_err[i] = int'(od[i]) - exq[rd[i]];
          else if ((exq[rd[i]] - int'(od[i])) > max_err[i]) max_err[i] = exq[rd[i]] - int'(od[i]);
          rd[i]++;
        end
      end
      if (in_valid && ir[0]) begin
        model_step(stim[sent]);
        sent++;
      end
      stalled = ov[0] && !out_ready;
    end
    if (cyc >= 20000) chk(1'b0, "R2 phase stuck", cyc, 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) max_err[i] = 0;
    do_reset();

    // directed: enter high, stay, step in, drop low, back inside
    stim[0] = 90; stim[1] = 8; stim[2] = -5; stim[3] = -100; stim[4] = 30;
    run_phase(5, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk(got[i][0] == 88, "R9 first", got[i][0], 88);
      chk(got[i][1] == 88, "R9 second", got[i][1], 88);
      chk(got[i][2] == 83, "R6 inward step", got[i][2], 83);
      chk(got[i][3] == 0,  "R4 enter low", got[i][3], 0);
      chk(got[i][4] == 30, "R5 inside", got[i][4], 30);
    end

    // directed: staying above with floating base gives the known deviation
    do_reset();
    stim[0] = 100; stim[1] = -5; stim[2] = 3; stim[3] = -200; stim[4] = -7;
    run_phase(5, 1'b0);
    chk(got[0][2] == 86, "R8 depth one exact", got[0][2], 86);
    chk(got[1][2] == 83, "R6 depth four stay", got[1][2], 83);
    chk(got[2][2] == 83, "R6 depth 32 stay", got[2][2], 83);
    chk(got[2][3] == 0,  "R4 enter low from high", got[2][3], 0);
    chk(got[2][4] == 0,  "R6 stay low", got[2][4], 0);

    // random with stalls on both sides
    do_reset();
    for (int k = 0; k < 600; k++) stim[k] = int'($urandom % 121) - 60;
    run_phase(600, 1'b1);

    do_reset();
    for (int k = 0; k < 300; k++) stim[k] = int'($urandom % 401) - 200;
    run_phase(300, 1'b1);

    $display("[TB] info: max deviation from exact clamp depth4=%0d depth32=%0d",
             max_err[1], max_err[2]);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule